// File: doc/BRIEF.md
# NAND Sector Read Sequencer with Per-Sector ECC Fetch

This block reads one NAND page as a series of 512-byte sectors. For every sector it requests a data read at that sector's column, streams the 512 bytes to a downstream buffer, and then at once requests the spare-area reads that hold that sector's 13 ECC bytes. Only after those bytes are packed does it hand them to an external correction unit and move on to the next sector. The correction unit reports either a failure or a count of repaired bits. The block keeps a running total of each for the page.

Commands go to a NAND port model through a valid/ready channel. Each command carries a spare/main flag, the page, a column and a byte length. Read bytes come back on a valid/ready byte stream. During a sector's main data the stream passes straight through to the buffer port. `rd_ready` follows `buf_ready`, and `buf_valid` follows `rd_valid`, with no storage in between. So downstream back-pressure stalls the NAND side beat for beat, and a byte moves only in a cycle where both `rd_valid` and `buf_ready` are high. During spare reads the block always accepts bytes.

The correction handoff is a level `corr_valid` that stays high until `corr_ready`. The `corr_fail` and `corr_count` inputs are sampled in the cycle where `corr_ready` is high.

Top module: `nand_sector_reader`

## Requirements
- R1: After reset `busy`, `done`, `cmd_valid`, `buf_valid` and `corr_valid` are low and both totals are zero.
- R2: A `start` pulse is taken only while `busy` is low. It latches `start_page`, `small_page` and `bus16`, and clears both totals. A `start` seen while busy has no effect: commands keep the original page and mode, the totals are not cleared, and one run produces exactly one `done`.
- R3: The main-data command for sector s has `cmd_spare`=0, column s*512, length 512 and the latched page.
- R4: Exactly 512 main bytes per sector reach the buffer port unchanged and in order, under back-pressure. `buf_last` is high on the 512th byte only.
- R5: With `small_page`=0, sector s uses one spare command with `cmd_spare`=1, column 2+16*s and length 13, or 14 when `bus16`=1.
- R6: With `small_page`=1, the sector uses two spare commands: column 0 with length 4, then column 6 with length 9, or 10 when `bus16`=1.
- R7: The first 13 spare bytes of a sector are packed into `corr_ecc`, with byte i at bits [8i+7:8i]. Spare bytes after the 13th are accepted and dropped.
- R8: A sector's spare commands come right after its 512th main byte and before any later main-data command.
- R9: `corr_valid` stays high until `corr_ready`. On that handshake, `corr_fail`=1 adds one to `failed_total`; otherwise `corr_count` is added to `corrected_total`.
- R10: A page has 1 sector when `small_page`=1 and `LP_SECTORS` sectors otherwise.
- R11: After the last sector's handshake, `done` is high for exactly one cycle and `busy` then falls.
- R12: While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page read (taken when idle) |
| start_page | input | PAGE_W | Page number to read |
| small_page | input | 1 | 1: 512-byte page, 0: large page |
| bus16 | input | 1 | 1: 16-bit device bus (even spare lengths) |
| busy | output | 1 | A page read is in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Port model accepts command |
| cmd_spare | output | 1 | 1: spare-area read, 0: main-data read |
| cmd_page | output | PAGE_W | Page of the command |
| cmd_col | output | COL_W | Column (byte offset in main or spare area) |
| cmd_len | output | LEN_W | Bytes to read |
| rd_valid | input | 1 | Read byte valid |
| rd_ready | output | 1 | Read byte accepted |
| rd_data | input | 8 | Read byte |
| buf_valid | output | 1 | Sector byte valid toward the buffer |
| buf_ready | input | 1 | Buffer accepts byte |
| buf_data | output | 8 | Sector byte |
| buf_last | output | 1 | Last byte of the sector |
| corr_valid | output | 1 | ECC bytes ready for correction |
| corr_ready | input | 1 | Correction finished, result present |
| corr_ecc | output | 8*ECC_BYTES | Packed ECC bytes of the sector |
| corr_fail | input | 1 | Sector uncorrectable |
| corr_count | input | CORR_W | Number of bits corrected |
| corrected_total | output | CNT_W | Sum of corrected bits this page |
| failed_total | output | CNT_W | Number of failed sectors this page |

## Verification
The stress point is a `start` pulse that arrives in the same cycle as live sequencer work: during a main-data stream that is stalled by back-pressure, or during a spare fetch. The bench injects such a pulse with a different page and mode while the page read runs. It then judges the run by the page and columns of every later command, by totals that were never cleared, and by a single `done`. A second overlap is the last main byte of a sector meeting randomly toggling `buf_ready` and `rd_valid`. The bench checks that `buf_last` marks the 512th accepted byte and that the next command is that sector's spare read.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA_CMD,
    ST_DATA_XFER,
    ST_OOB_CMD,
    ST_OOB_XFER,
    ST_CORRECT,
    ST_NEXT,
    ST_DONE
  } seq_state_e;

  localparam int SPARE_COL_W = 8;
  localparam int SPARE_LEN_W = 5;

  // large-page spare layout: one group per sector
  localparam int LP_SPARE_BASE   = 2;
  localparam int LP_SPARE_STRIDE = 16;
  localparam int LP_SPARE_LEN    = 13;

  // small-page spare layout: two groups for the single sector
  localparam int SP_G0_COL = 0;
  localparam int SP_G0_LEN = 4;
  localparam int SP_G1_COL = 6;
  localparam int SP_G1_LEN = 9;

endpackage

// File: rtl/nsr_group_table.sv
module nsr_group_table
  import nsr_pkg::*;
#(
  parameter int SECT_W = 2
) (
  input  logic                   small_page,
  input  logic                   bus16,
  input  logic [SECT_W-1:0]      sector,
  input  logic                   grp,
  output logic [SPARE_COL_W-1:0] grp_col,
  output logic [SPARE_LEN_W-1:0] grp_len,
  output logic                   grp_last
);

  logic [SPARE_LEN_W-1:0] raw_len;

  always_comb begin
    if (small_page) begin
      grp_col  = grp ? SPARE_COL_W'(SP_G1_COL) : SPARE_COL_W'(SP_G0_COL);
      raw_len  = grp ? SPARE_LEN_W'(SP_G1_LEN) : SPARE_LEN_W'(SP_G0_LEN);
      grp_last = grp;
    end else begin
      grp_col  = SPARE_COL_W'(LP_SPARE_BASE)
               + SPARE_COL_W'(SPARE_COL_W'(sector) * SPARE_COL_W'(LP_SPARE_STRIDE));
      raw_len  = SPARE_LEN_W'(LP_SPARE_LEN);
      grp_last = 1'b1;
    end
    // a 16-bit bus moves whole words: round odd lengths up
    grp_len = bus16 ? raw_len + SPARE_LEN_W'(raw_len[0]) : raw_len;
  end

endmodule

// File: rtl/nsr_ecc_collect.sv
module nsr_ecc_collect #(
  parameter int ECC_BYTES = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   byte_valid,
  input  logic [7:0]             byte_in,
  output logic [8*ECC_BYTES-1:0] ecc,
  output logic [$clog2(ECC_BYTES+1)-1:0] fill
);

  localparam int IDX_W = $clog2(ECC_BYTES + 1);

  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign take = byte_valid && (idx_q < IDX_W'(ECC_BYTES));
  assign fill = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (clr)       idx_q <= '0;
    else if (take)      idx_q <= idx_q + 1'b1;
  end

  for (genvar i = 0; i < ECC_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ecc[8*i +: 8] <= '0;
      else if (clr)                             ecc[8*i +: 8] <= '0;
      else if (take && idx_q == IDX_W'(i))      ecc[8*i +: 8] <= byte_in;
    end
  end

  assert_fill_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= IDX_W'(ECC_BYTES));

  assert_extra_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !clr && fill == IDX_W'(ECC_BYTES)) |=> $stable(ecc));

endmodule

// File: rtl/nsr_tally.sv
module nsr_tally #(
  parameter int CNT_W  = 16,
  parameter int CORR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              fail,
  input  logic [CORR_W-1:0] count,
  output logic [CNT_W-1:0]  corrected,
  output logic [CNT_W-1:0]  failed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrected <= '0;
      failed    <= '0;
    end else if (clr) begin
      corrected <= '0;
      failed    <= '0;
    end else if (upd) begin
      if (fail) failed    <= failed + 1'b1;
      else      corrected <= corrected + CNT_W'(count);
    end
  end

  assert_fail_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && fail && !clr) |=> (failed == $past(failed) + 1'b1) && $stable(corrected));

  assert_corr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fail && !clr) |=> (corrected == $past(corrected) + CNT_W'($past(count))) && $stable(failed));

endmodule

// File: rtl/nand_sector_reader.sv
module nand_sector_reader
  import nsr_pkg::*;
#(
  parameter int PAGE_W       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int LP_SECTORS   = 4,
  parameter int ECC_BYTES    = 13,
  parameter int CORR_W       = 4,
  parameter int CNT_W        = 16,
  localparam int SECT_W      = (LP_SECTORS > 1) ? $clog2(LP_SECTORS) : 1,
  localparam int BYTE_SH     = $clog2(SECTOR_BYTES),
  localparam int COL_W       = $clog2(LP_SECTORS * SECTOR_BYTES),
  localparam int LEN_W       = $clog2(SECTOR_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PAGE_W-1:0]      start_page,
  input  logic                   small_page,
  input  logic                   bus16,
  output logic                   busy,
  output logic                   done,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic                   cmd_spare,
  output logic [PAGE_W-1:0]      cmd_page,
  output logic [COL_W-1:0]       cmd_col,
  output logic [LEN_W-1:0]       cmd_len,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [7:0]             rd_data,
  output logic                   buf_valid,
  input  logic                   buf_ready,
  output logic [7:0]             buf_data,
  output logic                   buf_last,
  output logic                   corr_valid,
  input  logic                   corr_ready,
  output logic [8*ECC_BYTES-1:0] corr_ecc,
  input  logic                   corr_fail,
  input  logic [CORR_W-1:0]      corr_count,
  output logic [CNT_W-1:0]       corrected_total,
  output logic [CNT_W-1:0]       failed_total
);

  localparam int FILL_W = $clog2(ECC_BYTES + 1);

  seq_state_e          state_q;
  logic [PAGE_W-1:0]   page_q;
  logic                small_q, bus16_q;
  logic [SECT_W-1:0]   sector_q;
  logic                grp_q;
  logic [LEN_W-1:0]    beat_q, xfer_len_q;

  logic [SPARE_COL_W-1:0] grp_col;
  logic [SPARE_LEN_W-1:0] grp_len;
  logic                   grp_last;
  logic [FILL_W-1:0]      ecc_fill;

  logic accept, rd_fire, data_end, oob_end, last_sector, ecc_clr;

  nsr_group_table #(.SECT_W(SECT_W)) u_table (
    .small_page (small_q),
    .bus16      (bus16_q),
    .sector     (sector_q),
    .grp        (grp_q),
    .grp_col    (grp_col),
    .grp_len    (grp_len),
    .grp_last   (grp_last)
  );

  // ---------------- outputs ----------------
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign cmd_valid  = (state_q == ST_DATA_CMD) || (state_q == ST_OOB_CMD);
  assign cmd_spare  = (state_q == ST_OOB_CMD);
  assign cmd_page   = page_q;
  assign cmd_col    = cmd_spare ? COL_W'(grp_col) : (COL_W'(sector_q) << BYTE_SH);
  assign cmd_len    = cmd_spare ? LEN_W'(grp_len) : LEN_W'(SECTOR_BYTES);
  assign rd_ready   = (state_q == ST_DATA_XFER) ? buf_ready : (state_q == ST_OOB_XFER);
  assign buf_valid  = (state_q == ST_DATA_XFER) && rd_valid;
  assign buf_data   = rd_data;
  assign buf_last   = (beat_q == LEN_W'(SECTOR_BYTES - 1));
  assign corr_valid = (state_q == ST_CORRECT);

  assign accept      = (state_q == ST_IDLE) && start;
  assign rd_fire     = rd_valid && rd_ready;
  assign data_end    = (state_q == ST_DATA_XFER) && rd_fire && buf_last;
  assign oob_end     = (state_q == ST_OOB_XFER) && rd_fire && (beat_q == xfer_len_q - 1'b1);
  assign last_sector = small_q ? (sector_q == '0) : (sector_q == SECT_W'(LP_SECTORS - 1));
  assign ecc_clr     = data_end;

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      small_q    <= 1'b0;
      bus16_q    <= 1'b0;
      sector_q   <= '0;
      grp_q      <= 1'b0;
      beat_q     <= '0;
      xfer_len_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          page_q   <= start_page;
          small_q  <= small_page;
          bus16_q  <= bus16;
          sector_q <= '0;
          state_q  <= ST_DATA_CMD;
        end
        ST_DATA_CMD: if (cmd_ready) begin
          beat_q  <= '0;
          state_q <= ST_DATA_XFER;
        end
        ST_DATA_XFER: if (rd_fire) begin
          beat_q <= beat_q + 1'b1;
          if (buf_last) begin
            grp_q   <= 1'b0;
            state_q <= ST_OOB_CMD;
          end
        end
        ST_OOB_CMD: if (cmd_ready) begin
          beat_q     <= '0;
          xfer_len_q <= LEN_W'(grp_len);
          state_q    <= ST_OOB_XFER;
        end
        ST_OOB_XFER: if (rd_fire) begin
          beat_q <= beat_q + 1'b1;
          if (oob_end) begin
            if (grp_last) state_q <= ST_CORRECT;
            else begin
              grp_q   <= 1'b1;
              state_q <= ST_OOB_CMD;
            end
          end
        end
        ST_CORRECT: if (corr_ready) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (last_sector) state_q <= ST_DONE;
          else begin
            sector_q <= sector_q + 1'b1;
            state_q  <= ST_DATA_CMD;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nsr_ecc_collect #(.ECC_BYTES(ECC_BYTES)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ecc_clr),
    .byte_valid ((state_q == ST_OOB_XFER) && rd_fire),
    .byte_in    (rd_data),
    .ecc        (corr_ecc),
    .fill       (ecc_fill)
  );

  nsr_tally #(.CNT_W(CNT_W), .CORR_W(CORR_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .upd       (corr_valid && corr_ready),
    .fail      (corr_fail),
    .count     (corr_count),
    .corrected (corrected_total),
    .failed    (failed_total)
  );

  // ---------------- assertions ----------------
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_spare) && $stable(cmd_col)
                                  && $stable(cmd_len) && $stable(cmd_page));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_corr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_valid && !corr_ready) |=> corr_valid && $stable(corr_ecc));

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> $stable(page_q) && $stable(small_q) && $stable(bus16_q));

  assert_spare_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_spare && !grp_q) |-> (ecc_fill == '0));

  assert_ecc_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> (ecc_fill == FILL_W'(ECC_BYTES)));

endmodule

// File: tb/nand_sector_reader_test.sv
module nand_sector_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int LP_SECT    = 4;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] start_page = '0;
  logic small_page = 1'b0, bus16 = 1'b0;
  logic busy, done;
  logic cmd_valid, cmd_ready = 1'b0, cmd_spare;
  logic [15:0] cmd_page;
  logic [10:0] cmd_col;
  logic [9:0]  cmd_len;
  logic rd_valid = 1'b0, rd_ready;
  logic [7:0] rd_data = '0;
  logic buf_valid, buf_ready = 1'b0, buf_last;
  logic [7:0] buf_data;
  logic corr_valid, corr_ready = 1'b0, corr_fail = 1'b0;
  logic [103:0] corr_ecc;
  logic [3:0] corr_count = '0;
  logic [15:0] corrected_total, failed_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_sector_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .small_page(small_page), .bus16(bus16), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_spare(cmd_spare),
    .cmd_page(cmd_page), .cmd_col(cmd_col), .cmd_len(cmd_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_data(buf_data), .buf_last(buf_last),
    .corr_valid(corr_valid), .corr_ready(corr_ready), .corr_ecc(corr_ecc),
    .corr_fail(corr_fail), .corr_count(corr_count),
    .corrected_total(corrected_total), .failed_total(failed_total)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit hung = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] data_byte(input int page, input int col);
    return 8'(page * 7) ^ 8'(col) ^ {3'(col >> 8), 5'd0};
  endfunction

  function automatic logic [7:0] spare_byte(input int page, input int col);
    return 8'hA5 ^ 8'(page) ^ 8'(col * 3);
  endfunction

  function automatic logic [103:0] exp_ecc(input bit sm, input int page, input int s);
    logic [103:0] e;
    for (int i = 0; i < 13; i++)
      e[8*i +: 8] = spare_byte(page, sm ? (i < 4 ? i : i + 2) : 2 + 16*s + i);
    return e;
  endfunction

  function automatic int rnd_len(input bit b16, input int x);
    return b16 ? x + (x % 2) : x;
  endfunction

  // expectation state for the current page
  bit  exp_spare [16];
  int  exp_col [16], exp_len [16];
  int  exp_n, exp_sect, cmd_i, corr_seen, done_count;
  int  run_page_v;
  bit  run_small;
  int  exp_corr, exp_fail;

  task automatic build_expect(input bit sm, input bit b16);
    exp_n = 0;
    exp_sect = sm ? 1 : LP_SECT;
    for (int s = 0; s < exp_sect; s++) begin
      exp_spare[exp_n] = 0; exp_col[exp_n] = s * 512; exp_len[exp_n] = 512; exp_n++;
      if (sm) begin
        exp_spare[exp_n] = 1; exp_col[exp_n] = 0; exp_len[exp_n] = rnd_len(b16, 4); exp_n++;
        exp_spare[exp_n] = 1; exp_col[exp_n] = 6; exp_len[exp_n] = rnd_len(b16, 9); exp_n++;
      end else begin
        exp_spare[exp_n] = 1; exp_col[exp_n] = 2 + 16*s; exp_len[exp_n] = rnd_len(b16, 13); exp_n++;
      end
    end
  endtask

  // NAND port / buffer / correction model
  bit act = 0, act_spare = 0, prev_done = 0, prev_hold = 0;
  int act_col = 0, act_len = 0, beat = 0, corr_wait = 0;
  logic [10:0] hold_col;
  logic [9:0]  hold_len;

  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      cmd_ready = ($urandom % 10) < 7;
      if (act) begin
        rd_valid = ($urandom % 4) != 0;
        rd_data  = act_spare ? spare_byte(run_page_v, act_col + beat)
                             : data_byte(run_page_v, act_col + beat);
      end else begin
        rd_valid = 1'b0;
        rd_data  = 8'($urandom);
      end
      buf_ready = ($urandom % 10) < 7;
      if (corr_valid && corr_wait == 0) begin
        corr_ready = 1'b1;
        corr_fail  = ($urandom % 4) == 0;
        corr_count = 4'($urandom % 9);
      end else begin
        corr_ready = 1'b0;
        if (corr_wait > 0) corr_wait--;
      end
      #1;
      if (prev_hold) // R12 command stays put under back-pressure
        chk(cmd_valid && cmd_col == hold_col && cmd_len == hold_len, "R12 cmd hold",
            {cmd_valid, cmd_col}, {1'b1, hold_col});
      prev_hold = cmd_valid && !cmd_ready;
      hold_col = cmd_col; hold_len = cmd_len;

      if (cmd_valid && cmd_ready) begin
        chk(!act, "R8 cmd during stream", act, 0);
        if (cmd_i < exp_n) begin
          chk(cmd_spare == exp_spare[cmd_i], exp_spare[cmd_i] ? "R8 spare order" : "R3 data kind",
              cmd_spare, exp_spare[cmd_i]);
          chk(int'(cmd_col) == exp_col[cmd_i],
              exp_spare[cmd_i] ? (run_small ? "R6 spare col" : "R5 spare col") : "R3 data col",
              cmd_col, exp_col[cmd_i]);
          chk(int'(cmd_len) == exp_len[cmd_i],
              exp_spare[cmd_i] ? (run_small ? "R6 spare len" : "R5 spare len") : "R3 data len",
              cmd_len, exp_len[cmd_i]);
          chk(int'(cmd_page) == run_page_v, "R2 page kept", cmd_page, run_page_v);
        end else chk(0, "R10 extra command", cmd_i, exp_n);
        cmd_i++;
        act = 1; act_spare = cmd_spare; act_col = int'(cmd_col); act_len = int'(cmd_len); beat = 0;
      end else if (act && rd_valid && rd_ready) begin
        if (!act_spare) begin
          chk(buf_valid && buf_data == data_byte(run_page_v, act_col + beat), "R4 buf data",
              {buf_valid, buf_data}, {1'b1, data_byte(run_page_v, act_col + beat)});
          chk(buf_last == (beat == 511), "R4 buf_last", buf_last, beat == 511);
        end
        beat++;
        if (beat == act_len) act = 0;
      end
      if (corr_valid && corr_ready) begin
        chk(corr_ecc == exp_ecc(run_small, run_page_v, corr_seen), "R7 ecc packing",
            corr_ecc, exp_ecc(run_small, run_page_v, corr_seen));
        if (corr_fail) exp_fail++; else exp_corr += int'(corr_count);
        corr_seen++;
        corr_wait = $urandom % 4;
      end
      if (done) begin
        chk(!prev_done, "R11 done width", prev_done, 0);
        chk(int'(failed_total) == exp_fail, "R9 failed total", failed_total, exp_fail);
        chk(int'(corrected_total) == exp_corr, "R9 corrected total", corrected_total, exp_corr);
        chk(corr_seen == exp_sect, "R10 sector count", corr_seen, exp_sect);
        chk(cmd_i == exp_n, "R8 command count", cmd_i, exp_n);
        done_count++;
      end
      prev_done = done;
    end
  end

  task automatic run_page(input int page, input bit sm, input bit b16, input bit inject);
    int d0;
    build_expect(sm, b16);
    run_page_v = page; run_small = sm;
    exp_corr = 0; exp_fail = 0; cmd_i = 0; corr_seen = 0;
    d0 = done_count;
    @(negedge clk);
    start = 1'b1; start_page = 16'(page); small_page = sm; bus16 = b16;
    @(negedge clk);
    start = 1'b0; start_page = 16'($urandom); small_page = ~sm; bus16 = ~b16;
    if (inject) begin // R2: start while busy must be ignored
      repeat (40) @(negedge clk);
      start = 1'b1; start_page = ~16'(page);
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_count == d0 && cyc < WATCHDOG) @(negedge clk);
    if (done_count == d0) begin
      hung = 1;
      chk(0, "R11 watchdog expired", cyc, WATCHDOG);
    end else begin
      repeat (5) @(negedge clk);
      #2;
      chk(done_count == d0 + 1, "R2 one done per run", done_count - d0, 1);
      chk(!busy, "R11 busy after done", busy, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!cmd_valid && !buf_valid && !corr_valid, "R1 reset valids",
        {cmd_valid, buf_valid, corr_valid}, 0);
    chk(corrected_total == 0 && failed_total == 0, "R1 reset totals",
        {corrected_total, failed_total}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_page(5, 1, 0, 0);                 // R6 small, 8-bit
    if (!hung) run_page(300, 1, 1, 0);    // R6 R7 small, 16-bit (14th byte dropped)
    if (!hung) run_page(77, 0, 0, 0);     // R5 R10 large, 8-bit
    if (!hung) run_page(1234, 0, 1, 1);   // R5 R2 large, 16-bit, start while busy
    if (!hung) run_page(9, 1, 1, 1);      // R2 small with injected start
    for (int k = 0; k < 5 && !hung; k++)
      run_page(int'($urandom % 65536), 1'($urandom), 1'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule